// File: doc/BRIEF.md
# Nine-Bit Framed Serial Transmitter

This block drives one asynchronous serial line with frames that carry a ninth data bit. A single write strobe delivers a data byte. In the same cycle it captures the current ninth-bit setting from a control input and places both values in a shift register. The block then waits for the next wrap of its own divide-by-16 tick counter before it puts the start bit on the line. Every later bit boundary also falls on one of these wraps, so the bit timing is set by the counter and never by the moment of the write.

The block does not count bits. On its first shift it moves a single 1 (the stop marker) in from the top of the register, and every later shift fills with 0. When the register holds only that marker, sitting just above the ninth bit, the control makes one last shift, returns the line to idle and raises a done flag. The flag stays high until the host pulses the clear input. This lets one master send address frames (ninth bit 1) and data frames (ninth bit 0) to several listeners.

Top module: `ninebit_frame_tx`

## Requirements
- R1: While reset is high and after it is released with no write pending, `tx_out` is 1 and `tx_done` is 0.
- R2: A frame on `tx_out` is: a 0 start bit, then data bits 0 through 7 (least significant first), then the ninth bit, then a 1 that is held until the next frame. Each bit lasts 16 `baud_tick` pulses.
- R3: The divider counts `baud_tick` pulses from 0 after reset. A wrap is a tick that arrives while the count is 15. The start bit appears on the first wrap that falls strictly after the cycle of the accepted write. A wrap in the same cycle as the write does not count.
- R4: `tx_out` changes only in cycles that follow a wrap.
- R5: The ninth bit sent is the value of `ninth_cfg` in the write cycle. Later changes to `ninth_cfg` do not alter the frame in flight.
- R6: `tx_done` rises at the 11th wrap after the write. In the same cycle `tx_out` returns to 1.
- R7: `tx_done` stays 1 until `done_clr` is pulsed. If `done_clr` falls in the same cycle as the wrap that completes a frame, the flag ends up 1.
- R8: A write while a frame is pending or in progress is ignored: the frame on the line and its ninth bit are unchanged.
- R9: A write in the cycle after `tx_done` rises is accepted and starts a full new frame.
- R10: The frame length does not depend on the data. This includes a byte whose loaded register already looks like the end pattern (data 0x02 with ninth bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| wr_stb | input | 1 | Write strobe for a new frame |
| wr_data | input | DATA_W | Data byte captured on the write |
| ninth_cfg | input | 1 | Ninth-bit value captured on the write |
| done_clr | input | 1 | Clears the done flag |
| tx_out | output | 1 | Serial line, idle high |
| tx_done | output | 1 | Frame-complete flag |

## Verification
The clear input and the end of a frame can land in the same cycle. The bench tracks the wrap count with its own copy of the divider. It then pulses `done_clr` exactly in the cycle of the 11th wrap, while the flag is already set from the previous frame, and expects the flag to read 1 afterwards. A second pair is a write that coincides with a divider wrap. The bench places that write on a wrap cycle and expects the start bit only one full bit time later.

// File: rtl/ntx_pkg.sv
package ntx_pkg;

    localparam int unsigned DATA_W_DEF = 8;
    localparam int unsigned DIV_DEF    = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_LEAD  = 2'd2,
        PH_SHIFT = 2'd3
    } ph_t;

    typedef struct packed {
        logic load;
        logic shift;
        logic fill;
    } sh_cmd_t;

    function automatic logic line_level(input ph_t ph, input logic sr_out);
        case (ph)
            PH_IDLE:  return 1'b1;
            PH_START: return 1'b0;
            default:  return sr_out;
        endcase
    endfunction

endpackage

// File: rtl/ntx_divider.sv
module ntx_divider #(
    parameter int unsigned DIV = ntx_pkg::DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic roll
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign roll = tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ntx_shifter.sv
module ntx_shifter #(
    parameter int unsigned DATA_W = ntx_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  ntx_pkg::sh_cmd_t  cmd,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_ninth,
    output logic              out_bit,
    output logic              at_end
);
    localparam int unsigned SH_W = DATA_W + 1;

    logic [SH_W-1:0] sr;

    assign out_bit = sr[0];
    assign at_end  = sr[1] && (sr[SH_W-1:2] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else if (cmd.load) begin
            sr <= {ld_ninth, ld_data};
        end else if (cmd.shift) begin
            sr <= {cmd.fill, sr[SH_W-1:1]};
        end
    end
endmodule

// File: rtl/ntx_ctrl.sv
module ntx_ctrl
    import ntx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    roll,
    input  logic    wr_stb,
    input  logic    at_end,
    input  logic    done_clr,
    output sh_cmd_t cmd,
    output ph_t     phase,
    output logic    busy,
    output logic    done_flag
);
    logic req;
    logic accept;
    logic finish;

    assign busy   = req || (phase != PH_IDLE);
    assign accept = wr_stb && !busy;
    assign finish = roll && (phase == PH_SHIFT) && at_end;

    always_comb begin
        cmd.load  = accept;
        cmd.shift = roll && ((phase == PH_LEAD) || (phase == PH_SHIFT));
        cmd.fill  = (phase == PH_LEAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= 1'b0;
            phase     <= PH_IDLE;
            done_flag <= 1'b0;
        end else begin
            if (accept) req <= 1'b1;
            if (roll) begin
                case (phase)
                    PH_IDLE: begin
                        if (req) begin
                            phase <= PH_START;
                            req   <= 1'b0;
                        end
                    end
                    PH_START: phase <= PH_LEAD;
                    PH_LEAD:  phase <= PH_SHIFT;
                    PH_SHIFT: if (at_end) phase <= PH_IDLE;
                    default:  phase <= PH_IDLE;
                endcase
            end
            if (finish)        done_flag <= 1'b1;
            else if (done_clr) done_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ninebit_frame_tx.sv
module ninebit_frame_tx #(
    parameter int unsigned DATA_W = ntx_pkg::DATA_W_DEF,
    parameter int unsigned DIV    = ntx_pkg::DIV_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ninth_cfg,
    input  logic              done_clr,
    output logic              tx_out,
    output logic              tx_done
);
    import ntx_pkg::*;

    logic    roll;
    logic    sr_out;
    logic    at_end;
    logic    busy;
    sh_cmd_t cmd;
    ph_t     phase;

    ntx_divider #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (baud_tick),
        .roll (roll)
    );

    ntx_shifter #(.DATA_W(DATA_W)) u_sh (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ld_data  (wr_data),
        .ld_ninth (ninth_cfg),
        .out_bit  (sr_out),
        .at_end   (at_end)
    );

    ntx_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .roll      (roll),
        .wr_stb    (wr_stb),
        .at_end    (at_end),
        .done_clr  (done_clr),
        .cmd       (cmd),
        .phase     (phase),
        .busy      (busy),
        .done_flag (tx_done)
    );

    assign tx_out = line_level(phase, sr_out);
endmodule

// File: rtl/ntx_checker.sv
module ntx_checker (
    input logic clk,
    input logic rst,
    input logic roll,
    input logic busy,
    input logic tx_out,
    input logic tx_done,
    input logic done_clr
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_out);

    p_start_on_roll_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_out) |-> $past(roll));

    p_line_holds_r4: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(tx_out));

    p_flag_on_roll_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> $past(roll));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (done_clr && !roll) |=> !tx_done);
endmodule

bind ninebit_frame_tx ntx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .roll     (roll),
    .busy     (busy),
    .tx_out   (tx_out),
    .tx_done  (tx_done),
    .done_clr (done_clr)
);

// File: tb/test_ninebit_frame_tx.sv
module test_ninebit_frame_tx;
    localparam int CLK_PER  = 10;
    localparam int TICK_DIV = 3;

    typedef struct {
        int         rw;
        logic [9:0] bits;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ninth_cfg = 1'b0;
    logic       done_clr = 1'b0;
    logic       tx_out;
    logic       tx_done;

    int errors = 0;
    int checks = 0;
    int bcnt = 0;
    int roll_cnt = 0;
    int tdiv = 0;
    int last_rw = 0;
    bit finished = 0;
    frame_t q[$];

    always #(CLK_PER/2) clk = ~clk;

    ninebit_frame_tx i_ninebit_frame_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_stb(wr_stb),
        .wr_data(wr_data), .ninth_cfg(ninth_cfg), .done_clr(done_clr),
        .tx_out(tx_out), .tx_done(tx_done)
    );

    // tick source
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TICK_DIV;
        baud_tick = (tdiv == 0);
    end

    // independent divider model
    always @(posedge clk) begin
        if (rst) begin
            bcnt <= 0;
            roll_cnt <= 0;
        end else if (baud_tick) begin
            if (bcnt == 15) roll_cnt <= roll_cnt + 1;
            bcnt <= (bcnt + 1) % 16;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (q.size() == 0) begin
                chk(tx_out == 1'b1, "R4 idle line", tx_out, 1);
            end else begin
                int n;
                n = roll_cnt - q[0].rw;
                if (n == 0) begin
                    chk(tx_out == 1'b1, "R3 no early start", tx_out, 1);
                end else if (n <= 10) begin
                    chk(tx_out == q[0].bits[n-1], "R2 frame bit", tx_out, q[0].bits[n-1]);
                end else begin
                    chk(tx_out == 1'b1, "R6 line back high", tx_out, 1);
                    chk(tx_done == 1'b1, "R6 done flag at 11th wrap", tx_done, 1);
                    void'(q.pop_front());
                end
            end
        end
    end

    task automatic wait_idle();
        do begin
            @(negedge clk); #2;
        end while (q.size() != 0);
    endtask

    task automatic wait_roll_cycle();
        // leave the caller just before an edge that carries a wrap
        do begin
            @(negedge clk); #1;
        end while (!(baud_tick && bcnt == 15));
    endtask

    task automatic send(input logic [7:0] d, input logic n9, input bit aligned);
        frame_t f;
        if (!aligned) begin
            @(negedge clk); #1;
        end
        wr_stb = 1'b1; wr_data = d; ninth_cfg = n9;
        @(posedge clk); #1;
        wr_stb = 1'b0;
        ninth_cfg = ~n9;          // R5: later change must not matter
        wr_data = ~d;
        f.rw = roll_cnt;
        f.bits = {n9, d, 1'b0};
        last_rw = f.rw;
        q.push_back(f);
    endtask

    task automatic stray_write(input logic [7:0] d);
        @(negedge clk); #1;
        wr_stb = 1'b1; wr_data = d; ninth_cfg = ~ninth_cfg;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); #1;
        done_clr = 1'b1;
        @(posedge clk); #1;
        done_clr = 1'b0;
        @(negedge clk);
        chk(tx_done == 1'b0, "R7 clear", tx_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_out == 1'b1, "R1 line in reset", tx_out, 1);
        chk(tx_done == 1'b0, "R1 flag in reset", tx_done, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        chk(tx_out == 1'b1, "R1 line after reset", tx_out, 1);
        chk(tx_done == 1'b0, "R1 flag after reset", tx_done, 0);

        // R2 / R5 basic frame
        send(8'hA5, 1'b1, 0);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(tx_done == 1'b1, "R7 flag holds", tx_done, 1);
        clear_flag();

        // R10 data that mimics the end pattern once loaded
        send(8'h02, 1'b0, 0);
        wait_idle();
        clear_flag();

        // R8 writes while pending and while in flight are ignored
        send(8'h00, 1'b0, 0);
        stray_write(8'hFF);
        while (roll_cnt < last_rw + 5) @(negedge clk);
        stray_write(8'h81);
        wait_idle();
        clear_flag();

        // R9 back-to-back frames, flag left set
        send(8'hFF, 1'b1, 0);
        wait_idle();
        send(8'h5A, 1'b0, 0);
        // R7 clear coinciding with the completing wrap
        while (roll_cnt < last_rw + 10) @(negedge clk);
        wait_roll_cycle();
        done_clr = 1'b1;
        @(posedge clk); #1;
        done_clr = 1'b0;
        @(negedge clk);
        chk(tx_done == 1'b1, "R7 set wins over clear", tx_done, 1);
        wait_idle();
        clear_flag();

        // R3 write landing on a wrap cycle
        wait_roll_cycle();
        send(8'h3C, 1'b1, 1);
        wait_idle();
        clear_flag();

        repeat (20) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule